// File: doc/BRIEF.md
# Single-Frame Lookahead Receive Buffer

This block stores one received frame of bytes and hands it to a host processor over a strobed 8-bit read path. Bytes enter from a byte-wide receive interface, one per valid cycle. The final byte of a frame carries an end-of-frame marker. The first byte of a new frame clears the previous frame and restarts both pointers at address zero. On the clock edge that stores the final byte, the block raises an interrupt line to the host.

Reads work in lookahead fashion. The byte the host will receive next is always already sitting in the output register. A host read strobe takes that byte and makes the block fetch the following one. As a result, the empty flag rises while the last byte is still waiting in the output register, so the host has to issue one more read after it sees empty. If the frame is longer than the storage depth, the extra bytes are dropped and a sticky overflow flag is set. That flag stays set until the next frame begins.

Top module: `rx_lookahead_fifo`

## Requirements
- R1: After reset, `rx_empty` is 1, `eof_irq` is 0, `overflow` is 0 and `rd_data` is 0x00.
- R2: On the clock edge that accepts a byte with `in_last`=1, `eof_irq` goes to 1 and `rd_data` shows the first byte of that frame.
- R3: Each `rd_strobe` pulse during a stored frame replaces `rd_data` with the next stored byte, in the order the bytes arrived.
- R4: `rx_empty` is 1 exactly when `rd_data` shows the final stored byte of the frame. It is also 1 whenever no complete frame is stored.
- R5: A `rd_strobe` while `rd_data` shows the final stored byte leaves `rd_data` and `rx_empty` unchanged.
- R6: `eof_irq` stays 1 until the first `rd_strobe` after the frame completes, and is 0 from the edge of that strobe onward.
- R7: The first byte of a new frame (a valid byte that arrives after reset or after an end-of-frame byte) clears `eof_irq` and `overflow` and sets `rx_empty` on that edge. The new frame is then read starting from its own first byte, however far the previous frame was read.
- R8: A frame holds at most DEPTH bytes (64 by default). Bytes beyond that are discarded, `overflow` goes to 1 and stays 1 until the next frame starts, and the frame then reads back as its first DEPTH bytes.
- R9: A `rd_strobe` while no complete frame is stored (after reset, or while a frame is being received) leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | The present byte ends the frame |
| rd_strobe | input | 1 | Host read pulse, one cycle per byte |
| rd_data | output | 8 | Byte prefetched for the host |
| rx_empty | output | 1 | Presented byte is the last one, or no frame is stored |
| eof_irq | output | 1 | Frame-complete interrupt |
| overflow | output | 1 | Sticky: bytes of the current frame were dropped |

## Verification
Every result is due one clock edge after the input that causes it. The end-of-frame byte updates `eof_irq`, `rd_data` and `rx_empty` on its own edge. A read strobe updates `rd_data`, `rx_empty` and `eof_irq` on its edge. A frame-start byte clears the flags on its edge. The bench changes inputs on the falling edge and samples outputs on the next falling edge, so every check falls half a period after the rising edge that should produce its result. The bench sweeps every frame length from one byte to three bytes past the storage depth. Some frames are abandoned after a partial read, and some read strobes are issued in the middle of reception.

// File: rtl/rxf_pkg.sv
// Shared types for the lookahead receive buffer.
package rxf_pkg;
    typedef logic [7:0] byte_t;
endpackage

// File: rtl/rxf_write_ctrl.sv
// Write side of the receive buffer.
// Detects the start and end of each frame, produces the write address,
// drops bytes once DEPTH bytes are stored, and keeps the sticky overflow flag.
// Assumes: one byte per in_valid cycle; every frame ends with in_last.
module rxf_write_ctrl #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_last,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic          frame_start,
    output logic          frame_done,
    output logic [CW-1:0] done_len,
    output logic          overflow
);
    logic          receiving;
    logic [CW-1:0] wr_cnt;
    logic          has_room;

    // Decode the frame events and the storage address of the current byte.
    always_comb begin
        has_room    = (wr_cnt < CW'(DEPTH));
        frame_start = in_valid && !receiving;
        frame_done  = in_valid && in_last;
        wr_en       = in_valid && (frame_start || has_room);
        wr_addr     = frame_start ? '0 : wr_cnt[AW-1:0];
        if (frame_start)
            done_len = CW'(1);
        else if (has_room)
            done_len = wr_cnt + CW'(1);
        else
            done_len = wr_cnt;
    end

    // Track reception state, the stored byte count and the overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            receiving <= 1'b0;
            wr_cnt    <= '0;
            overflow  <= 1'b0;
        end else if (frame_start) begin
            receiving <= !in_last;
            wr_cnt    <= CW'(1);
            overflow  <= 1'b0;
        end else if (in_valid) begin
            if (in_last)
                receiving <= 1'b0;
            if (has_room)
                wr_cnt <= wr_cnt + CW'(1);
            else
                overflow <= 1'b1;
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= CW'(DEPTH));
    assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !frame_start) |=> overflow);
    assert_start_clears_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !overflow);
endmodule

// File: rtl/rxf_mem.sv
// Byte storage for one frame: one write port, one asynchronous read port.
// A write and a read to the same address in the same cycle return the
// byte being written, so the first byte can be prefetched as it arrives.
// Assumes: contents have no reset and are read only after they are written.
module rxf_mem #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  rxf_pkg::byte_t wr_data,
    input  logic [AW-1:0]  rd_addr,
    output rxf_pkg::byte_t rd_data
);
    rxf_pkg::byte_t store [DEPTH];

    // Write the incoming byte at its address.
    always_ff @(posedge clk) begin
        if (wr_en)
            store[wr_addr] <= wr_data;
    end

    // Read with bypass of a write to the same address.
    always_comb begin
        if (wr_en && (wr_addr == rd_addr))
            rd_data = wr_data;
        else
            rd_data = store[rd_addr];
    end
endmodule

// File: rtl/rxf_read_ctrl.sv
// Read side of the receive buffer: lookahead prefetch register, read
// pointer, empty flag and end-of-frame interrupt.
// Assumes: rd_strobe lasts one cycle per byte; strobes are ignored
// while no complete frame is stored.
module rxf_read_ctrl #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_start,
    input  logic           frame_done,
    input  logic [CW-1:0]  done_len,
    input  logic           rd_strobe,
    output logic [AW-1:0]  mem_addr,
    input  rxf_pkg::byte_t mem_data,
    output rxf_pkg::byte_t rd_data,
    output logic           rx_empty,
    output logic           eof_irq
);
    logic          frame_valid;
    logic [AW-1:0] rd_ptr;
    logic [AW-1:0] last_idx;
    logic          at_last;

    // Choose the byte to prefetch and work out the empty flag.
    always_comb begin
        at_last  = (rd_ptr == last_idx);
        rx_empty = !frame_valid || at_last;
        mem_addr = frame_done ? '0 : rd_ptr + AW'(1);
    end

    // Update the frame state, pointer, prefetch register and interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_valid <= 1'b0;
            rd_ptr      <= '0;
            last_idx    <= '0;
            rd_data     <= '0;
            eof_irq     <= 1'b0;
        end else if (frame_done) begin
            frame_valid <= 1'b1;
            rd_ptr      <= '0;
            last_idx    <= AW'(done_len - CW'(1));
            rd_data     <= mem_data;
            eof_irq     <= 1'b1;
        end else if (frame_start) begin
            frame_valid <= 1'b0;
            rd_ptr      <= '0;
            eof_irq     <= 1'b0;
        end else if (frame_valid && rd_strobe) begin
            eof_irq <= 1'b0;
            if (!at_last) begin
                rd_ptr  <= rd_ptr + AW'(1);
                rd_data <= mem_data;
            end
        end
    end

    assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && rd_strobe && !frame_start) |=> !eof_irq);
    assert_irq_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (eof_irq && rd_ptr == '0));
    assert_empty_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_valid |-> rx_empty);
    assert_hold_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && at_last && rd_strobe && !frame_start) |=> ($stable(rd_data) && rx_empty));
    assert_ignore_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_valid && !frame_done) |=> $stable(rd_data));
    assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !frame_done) |=> (!eof_irq && rx_empty));
endmodule

// File: rtl/rx_lookahead_fifo.sv
// Top level of the single-frame lookahead receive buffer.
// Connects the write controller, the byte storage and the prefetching
// read controller. One frame is held at a time; each new frame
// overwrites the previous one from address zero.
// Assumes: synchronous active-low reset; the host samples rd_data
// together with its read strobe.
module rx_lookahead_fifo #(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    input  logic       rd_strobe,
    output logic [7:0] rd_data,
    output logic       rx_empty,
    output logic       eof_irq,
    output logic       overflow
);
    logic           wr_en;
    logic [AW-1:0]  wr_addr;
    logic           frame_start;
    logic           frame_done;
    logic [CW-1:0]  done_len;
    logic [AW-1:0]  mem_addr;
    rxf_pkg::byte_t mem_data;
    rxf_pkg::byte_t prefetch;

    rxf_write_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
        .wr_en(wr_en), .wr_addr(wr_addr), .frame_start(frame_start),
        .frame_done(frame_done), .done_len(done_len), .overflow(overflow)
    );

    rxf_mem #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(in_data),
        .rd_addr(mem_addr), .rd_data(mem_data)
    );

    rxf_read_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .frame_done(frame_done), .done_len(done_len), .rd_strobe(rd_strobe),
        .mem_addr(mem_addr), .mem_data(mem_data), .rd_data(prefetch),
        .rx_empty(rx_empty), .eof_irq(eof_irq)
    );

    // Drive the host data port from the prefetch register.
    always_comb rd_data = prefetch;
endmodule

// File: tb/rx_lookahead_fifo_test.sv
`timescale 1ns/100ps
module rx_lookahead_fifo_test;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rd_data;
    logic       rx_empty;
    logic       eof_irq;
    logic       overflow;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    rx_lookahead_fifo #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .rd_strobe(rd_strobe), .rd_data(rd_data),
        .rx_empty(rx_empty), .eof_irq(eof_irq), .overflow(overflow)
    );

    // Byte i of a frame of length len.
    function automatic logic [7:0] pat(input int len, input int i);
        return 8'((len * 7 + i * 13 + 5) & 255);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Called on a falling edge; returns on the next falling edge.
    task automatic send(input logic [7:0] d, input logic last);
        in_valid = 1'b1; in_data = d; in_last = last;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic strobe();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 empty", int'(rx_empty), 1);
        check("R1 irq", int'(eof_irq), 0);
        check("R1 overflow", int'(overflow), 0);
        check("R1 rd_data", int'(rd_data), 0);
        strobe();
        check("R9 strobe after reset", int'(rd_data), 0);
        check("R4 empty with no frame", int'(rx_empty), 1);
        prev = 8'h00;

        for (int len = 1; len <= DEPTH + 3; len++) begin
            int n;
            int reads;
            n = (len < DEPTH) ? len : DEPTH;
            reads = ((len % 5) == 0 && n > 2) ? 2 : n + 1;
            for (int i = 0; i < len; i++) begin
                send(pat(len, i), i == len - 1);
                if (i == 0 && len > 1) begin
                    check("R7 empty at start", int'(rx_empty), 1);
                    check("R7 irq at start", int'(eof_irq), 0);
                    check("R7 overflow at start", int'(overflow), 0);
                end
                if (i == 1 && len >= 3) begin
                    strobe();
                    check("R9 strobe during reception", int'(rd_data), int'(prev));
                end
            end
            check("R2 irq at end", int'(eof_irq), 1);
            check("R2 first byte", int'(rd_data), int'(pat(len, 0)));
            check("R8 overflow flag", int'(overflow), int'(len > DEPTH));
            for (int k = 0; k < reads; k++) begin
                int idx;
                idx = (k < n - 1) ? k : n - 1;
                check("R3 byte order", int'(rd_data), int'(pat(len, idx)));
                check("R4 empty flag", int'(rx_empty), int'(k >= n - 1));
                check("R6 irq until first read", int'(eof_irq), int'(k == 0));
                strobe();
            end
            prev = pat(len, (reads < n - 1) ? reads : n - 1);
            check("R5 last byte held", int'(rd_data), int'(prev));
            check("R6 irq cleared", int'(eof_irq), 0);
            check("R8 overflow sticky", int'(overflow), int'(len > DEPTH));
            if (reads > n - 1)
                check("R5 empty stays", int'(rx_empty), 1);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule